// File: doc/BRIEF.md
# Accumulator-Style 8-bit ALU

This block is the combinational datapath core of a small accumulator machine. It reads three operands at once: a value from the data bus, the accumulator contents and the index register contents. A 4-bit operation code chooses one of eleven functions. The block returns an 8-bit result, a carry/borrow flag and a zero flag. There is no state, so the outputs follow the inputs within the same cycle.

Surrounding logic owns the registers, the flag storage and instruction decode. It presents the operands and a code, then captures the three outputs at its own clock edge. No handshake applies: the block accepts a new operand set at any time and never stalls.

The five spare codes (11 to 15) give a fixed output, so a corrupted code still leads to a known value. Where a flag has no meaning for an operation, the block drives it to 0.

Top module: `acc_alu`

## Requirements
- R1: Code 0 (load) gives result = data bus value and carry = 0.
- R2: For every code, zero is 1 exactly when the 8-bit result is 0x00.
- R3: Code 1 (add) gives {carry, result} = accumulator + data, where carry is the carry out of bit 7.
- R4: Code 2 (subtract) gives result = (accumulator − data) mod 256. Carry is 1 exactly when accumulator < data as unsigned values (borrow).
- R5: Code 10 (compare) gives result = (index − data) mod 256. Carry is 1 exactly when index < data as unsigned values.
- R6: Code 3 gives the bitwise AND of accumulator and data. Code 4 gives the bitwise OR. Carry is 0 for both.
- R7: Code 5 (complement) gives result = bitwise NOT of the accumulator and carry = 1.
- R8: Code 6 (increment) gives result = (accumulator + 1) mod 256 and carry = 0, including when the accumulator is 0xFF.
- R9: Code 7 (logical shift right) gives result = accumulator >> 1 with bit 7 = 0, and carry = accumulator bit 0.
- R10: Code 8 (logical shift left) gives result = accumulator << 1 with bit 0 = 0, and carry = accumulator bit 7.
- R11: Code 9 (arithmetic shift right) gives result bits 6..0 = accumulator bits 7..1 and result bit 7 = accumulator bit 7. Carry = accumulator bit 0.
- R12: Codes 11 to 15 give result = 0x00, carry = 0 and zero = 1, whatever the operands.
- R13: The index operand has no effect on any output for every code other than 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 8 | Data-bus operand |
| acc_i | input | 8 | Accumulator operand |
| idx_i | input | 8 | Index-register operand (used only by compare) |
| op_i | input | 4 | Operation code, 0 to 10 assigned, 11 to 15 spare |
| result_o | output | 8 | Operation result |
| carry_o | output | 1 | Carry, borrow or shifted-out bit |
| zero_o | output | 1 | 1 when result_o is zero |

## Verification
All three outputs are due in the same cycle as the operands: there are zero register stages. The bench drives each operand set on a falling clock edge and samples just after the following rising edge. The outputs have therefore settled by the time they are read. For the R13 check, the bench alters only the index operand and samples again a short delay later, without moving on to a new clock. It then compares the two samples.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_COUNT = 11;
  localparam int SEL_W    = $clog2(OP_COUNT);

  typedef enum logic [SEL_W-1:0] {
    OP_LOAD = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_COM  = 4'd5,
    OP_INC  = 4'd6,
    OP_LSR  = 4'd7,
    OP_LSL  = 4'd8,
    OP_ASR  = 4'd9,
    OP_CMP  = 4'd10
  } alu_op_e;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] idx_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [SEL_W-1:0] op_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             flag_o
);
  localparam int EXT_W = WIDTH + 1;

  logic [WIDTH-1:0] a_opnd;
  logic [WIDTH-1:0] b_opnd;
  logic             cin;
  logic [EXT_W-1:0] wide;

  // One shared adder: subtract and compare use a + ~b + 1.
  always_comb begin
    a_opnd = acc_i;
    b_opnd = data_i;
    cin    = 1'b0;
    case (op_i)
      OP_SUB: begin b_opnd = ~data_i; cin = 1'b1; end
      OP_CMP: begin a_opnd = idx_i; b_opnd = ~data_i; cin = 1'b1; end
      OP_INC: begin b_opnd = '0; cin = 1'b1; end
      default: ;
    endcase
  end

  assign wide  = {1'b0, a_opnd} + {1'b0, b_opnd} + {{WIDTH{1'b0}}, cin};
  assign sum_o = wide[WIDTH-1:0];

  // Borrow is the inverse of the adder carry when subtracting.
  always_comb begin
    case (op_i)
      OP_ADD:         flag_o = wide[WIDTH];
      OP_SUB, OP_CMP: flag_o = ~wide[WIDTH];
      default:        flag_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] not_o
);
  assign and_o = acc_i & data_i;
  assign or_o  = acc_i | data_i;
  assign not_o = ~acc_i;
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  output logic [WIDTH-1:0] lsr_o,
  output logic [WIDTH-1:0] lsl_o,
  output logic [WIDTH-1:0] asr_o,
  output logic             low_out_o,
  output logic             high_out_o
);
  localparam int MSB = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == MSB) begin : g_top
      assign lsr_o[i] = 1'b0;
      assign asr_o[i] = acc_i[MSB];
    end else begin : g_mid
      assign lsr_o[i] = acc_i[i+1];
      assign asr_o[i] = acc_i[i+1];
    end
    if (i == 0) begin : g_low
      assign lsl_o[i] = 1'b0;
    end else begin : g_up
      assign lsl_o[i] = acc_i[i-1];
    end
  end

  assign low_out_o  = acc_i[0];
  assign high_out_o = acc_i[MSB];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] idx_i,
  input  logic [SEL_W-1:0] op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             zero_o
);
  logic [WIDTH-1:0] sum_w, and_w, or_w, not_w, lsr_w, lsl_w, asr_w;
  logic             arith_c, low_out, high_out;

  acc_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .acc_i(acc_i), .idx_i(idx_i), .data_i(data_i), .op_i(op_i),
    .sum_o(sum_w), .flag_o(arith_c)
  );

  acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .acc_i(acc_i), .data_i(data_i),
    .and_o(and_w), .or_o(or_w), .not_o(not_w)
  );

  acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .acc_i(acc_i), .lsr_o(lsr_w), .lsl_o(lsl_w), .asr_o(asr_w),
    .low_out_o(low_out), .high_out_o(high_out)
  );

  always_comb begin
    result_o = '0;
    carry_o  = 1'b0;
    case (op_i)
      OP_LOAD: result_o = data_i;
      OP_ADD, OP_SUB, OP_INC, OP_CMP: begin
        result_o = sum_w;
        carry_o  = arith_c;
      end
      OP_AND:  result_o = and_w;
      OP_OR:   result_o = or_w;
      OP_COM:  begin result_o = not_w; carry_o = 1'b1; end
      OP_LSR:  begin result_o = lsr_w; carry_o = low_out;  end
      OP_LSL:  begin result_o = lsl_w; carry_o = high_out; end
      OP_ASR:  begin result_o = asr_w; carry_o = low_out;  end
      default: begin result_o = '0; carry_o = 1'b0; end
    endcase
  end

  assign zero_o = ~|result_o;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] acc_i,
  input logic [WIDTH-1:0] idx_i,
  input logic [SEL_W-1:0] op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             zero_o
);
  localparam int EXT_W = WIDTH + 1;
  logic [EXT_W-1:0] add_ref;
  assign add_ref = {1'b0, acc_i} + {1'b0, data_i};

  always_comb begin
    p_zero_flag_r2: assert (zero_o == (result_o == '0))
      else $error("zero flag mismatch");
    if (op_i == OP_LOAD)
      p_load_r1: assert (result_o == data_i && !carry_o) else $error("load");
    if (op_i == OP_ADD)
      p_add_r3: assert ({carry_o, result_o} == add_ref) else $error("add");
    if (op_i == OP_SUB)
      p_sub_borrow_r4: assert (carry_o == (acc_i < data_i)) else $error("sub borrow");
    if (op_i == OP_CMP)
      p_cmp_borrow_r5: assert (carry_o == (idx_i < data_i)
                               && result_o + data_i == idx_i) else $error("cmp");
    if (op_i == OP_COM)
      p_com_r7: assert (carry_o && (result_o ^ acc_i) == '1) else $error("com");
    if (op_i == OP_LSR)
      p_lsr_r9: assert (!result_o[WIDTH-1] && carry_o == acc_i[0]) else $error("lsr");
    if (op_i == OP_LSL)
      p_lsl_r10: assert (!result_o[0] && carry_o == acc_i[WIDTH-1]) else $error("lsl");
    if (op_i == OP_ASR)
      p_asr_sign_r11: assert (result_o[WIDTH-1] == acc_i[WIDTH-1]
                              && carry_o == acc_i[0]) else $error("asr");
    if (op_i > OP_CMP)
      p_spare_r12: assert (result_o == '0 && !carry_o && zero_o) else $error("spare");
  end
endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .data_i(data_i), .acc_i(acc_i), .idx_i(idx_i), .op_i(op_i),
  .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o)
);

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] data_i, acc_i, idx_i;
  logic [3:0] op_i;
  logic [7:0] result_o;
  logic carry_o, zero_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu u0 (
    .data_i(data_i), .acc_i(acc_i), .idx_i(idx_i), .op_i(op_i),
    .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o)
  );

  function automatic string tag_of(int op);
    case (op)
      0: return "R1";  1: return "R3";  2: return "R4";  3: return "R6";
      4: return "R6";  5: return "R7";  6: return "R8";  7: return "R9";
      8: return "R10"; 9: return "R11"; 10: return "R5";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s op=%0d acc=%0d data=%0d idx=%0d got=%h exp=%h",
               tag, op_i, acc_i, data_i, idx_i, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int a, d, x, res, c, z, o1;
    data_i = '0; acc_i = '0; idx_i = '0; op_i = '0;
    repeat (3) @(posedge clk);
    #1;
    // Reset-time state: load of zero gives zero result, carry 0, zero 1 (R1, R2)
    check("R1", {carry_o, result_o}, 0);
    check("R2", int'(zero_o), 1);
    rst_n = 1'b1;

    for (int op = 0; op < 16; op++) begin
      for (int ai = 0; ai < 256; ai++) begin
        for (int k = 0; k < 16; k++) begin
          a = ai;
          d = k * 17;
          x = (ai * 7 + k * 31) % 256;
          @(negedge clk);
          op_i = 4'(op); acc_i = 8'(a); data_i = 8'(d); idx_i = 8'(x);
          c = 0;
          case (op)
            0:  res = d;
            1:  begin res = (a + d) % 256; c = (a + d > 255) ? 1 : 0; end
            2:  begin res = (a - d + 256) % 256; c = (a < d) ? 1 : 0; end
            3:  res = a & d;
            4:  res = a | d;
            5:  begin res = 255 - a; c = 1; end
            6:  res = (a + 1) % 256;
            7:  begin res = a / 2; c = a % 2; end
            8:  begin res = (a * 2) % 256; c = (a >= 128) ? 1 : 0; end
            9:  begin res = a / 2 + ((a >= 128) ? 128 : 0); c = a % 2; end
            10: begin res = (x - d + 256) % 256; c = (x < d) ? 1 : 0; end
            default: res = 0;
          endcase
          z = (res == 0) ? 1 : 0;
          @(posedge clk);
          #1;
          o1 = {zero_o, carry_o, result_o};
          check(tag_of(op), {carry_o, result_o}, c * 256 + res);
          check("R2", int'(zero_o), z);
          if (op != 10) begin
            idx_i = ~idx_i;
            #1;
            check("R13", {zero_o, carry_o, result_o}, o1);
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule